// File: doc/BRIEF.md
# Histogram-Based TDC Bin Calibrator

This block turns raw fine-time bin numbers from a delay-line TDC into calibrated times, and it builds its own calibration table from the same hit stream. The hits it books must have no timing relation to the TDC clock. The number of hits that land in a bin is then proportional to that bin's real width. After a fixed number of hits, the histogram is integrated in place into a table. Each entry of that table holds the calibrated centre of one bin.

Histogram and table share a single dual-port memory that is divided into two pages. The conversion side reads the live page, addressed by the incoming bin number. The maintenance side works only on the other page. It clears the page, counts hits into it, and then overwrites each count with a running centre value. A page flip lasting one cycle then makes the new table live. Conversion never stalls during any of this. After a flip the block starts a new round at once, so the table follows drift in temperature and supply.

Table values use a unit of half a hit count. The entry for bin k is twice the sum of the counts of all lower bins plus the count of bin k. No rounding is needed. With a clock period T and a hit total H, one unit stands for T/(2H).

Top module: `tdc_bin_calibrator`

## Requirements
- R1: While reset is held, `table_ready` and `cal_valid` are low and `cal_time` is zero.
- R2: Until the first page flip has taken effect, every conversion returns a `cal_time` of zero.
- R3: `cal_valid` rises exactly one cycle after each `hit_valid` and is low otherwise. `cal_time` keeps its last value in cycles without a conversion.
- R4: Every round begins with a clear phase that lasts exactly 2^BIN_W cycles. Hits that arrive during this phase are converted but are not counted.
- R5: During the booking phase, each valid hit adds one to the count of its bin. Booking ends with the HIT_TOTAL-th hit, and later hits are not counted.
- R6: After a flip, the conversion of bin k returns 2*(sum of counts of bins below k) + (count of bin k), taken from the round that was just integrated.
- R7: The page flip occupies one cycle. A conversion issued in that cycle still uses the old table. The next conversion uses the new table, and `table_ready` goes high at the flip.
- R8: After a flip the block starts the next round with no intervention. `table_ready` never falls again until reset.
- R9: The integration phase lasts exactly 2^BIN_W cycles. The flip comes immediately after it.
- R10: The maintenance side never writes to the page that the conversion side is reading.
- R11: The running sum used for integration never overflows DATA_W bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hit_valid | input | 1 | A fine-time code is present this cycle |
| hit_bin | input | BIN_W | Fine-time bin number of the hit |
| cal_valid | output | 1 | A calibrated time is present |
| cal_time | output | DATA_W | Calibrated bin centre, in half-count units |
| table_ready | output | 1 | A calibration table is live |

## Verification
The bench concentrates hits in bin 0 only and in the top bin only. With hits in bin 0 only, any hit counted during the clear phase, or beyond the hit total, would push entry 0 above HIT_TOTAL. A table built from bin edges instead of centres would give zero there. A continuous ramp and random gaps show whether a design loses hits or books the wrong page. A conversion issued in the flip cycle tells apart a design that switches to the new table one cycle early. The bench also counts the rounds, because a design that fails to restart after the flip leaves the table frozen.

// File: rtl/tdc_cal_pkg.sv
package tdc_cal_pkg;

    typedef enum logic [1:0] {
        ST_CLEAR = 2'd0,
        ST_BOOK  = 2'd1,
        ST_INTEG = 2'd2,
        ST_SWAP  = 2'd3
    } cal_state_e;

    typedef enum logic [1:0] {
        ACC_HOLD = 2'd0,
        ACC_ZERO = 2'd1,
        ACC_INC  = 2'd2,
        ACC_SUM  = 2'd3
    } acc_op_e;

endpackage

// File: rtl/tdc_cal_dpram.sv
module tdc_cal_dpram #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              a_en,
    input  logic [ADDR_W-1:0] a_addr,
    output logic [DATA_W-1:0] a_rdata,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic              b_we,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] a_rdata_q;

    // conversion port: registered read, held while not enabled
    always_ff @(posedge clk) begin
        if (a_en) a_rdata_q <= mem[a_addr];
    end

    // maintenance port: combinational read, registered write
    always_ff @(posedge clk) begin
        if (b_we) mem[b_addr] <= b_wdata;
    end

    assign a_rdata = a_rdata_q;
    assign b_rdata = mem[b_addr];

endmodule

// File: rtl/tdc_cal_accum.sv
module tdc_cal_accum
    import tdc_cal_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  acc_op_e           op,
    input  logic [DATA_W-1:0] rd_word,
    output logic [DATA_W-1:0] wr_word
);
    localparam logic [DATA_W-1:0] WORD_MAX = {DATA_W{1'b1}};

    logic [DATA_W-1:0] acc_d, acc_q;
    logic [DATA_W+1:0] wide_next;

    always_comb begin
        acc_d   = acc_q;
        wr_word = rd_word;
        case (op)
            ACC_ZERO: begin
                acc_d   = '0;
                wr_word = '0;
            end
            ACC_INC: begin
                wr_word = (rd_word == WORD_MAX) ? rd_word : rd_word + 1'b1;
            end
            ACC_SUM: begin
                wr_word = acc_q + rd_word;              // centre of this bin
                acc_d   = acc_q + {rd_word[DATA_W-2:0], 1'b0}; // edge of next bin
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    // full-precision sum, used only to check that nothing is lost
    assign wide_next = {2'b00, acc_q} + {1'b0, rd_word, 1'b0};

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (op == ACC_SUM) |-> (wide_next[DATA_W+1:DATA_W] == 2'b00)); // R11

endmodule

// File: rtl/tdc_cal_seq.sv
module tdc_cal_seq
    import tdc_cal_pkg::*;
#(
    parameter int BIN_W     = 7,
    parameter int HIT_TOTAL = 16384
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_valid,
    input  logic [BIN_W-1:0] hit_bin,
    output logic             page_o,
    output logic             ready_o,
    output logic [BIN_W:0]   b_addr_o,
    output logic             b_we_o,
    output acc_op_e          acc_op_o
);
    localparam int HIT_CW = $clog2(HIT_TOTAL + 1);
    localparam logic [BIN_W-1:0]  IDX_LAST = {BIN_W{1'b1}};
    localparam logic [HIT_CW-1:0] HIT_LAST = HIT_CW'(HIT_TOTAL - 1);

    typedef struct packed {
        cal_state_e        st;
        logic [BIN_W-1:0]  idx;
        logic [HIT_CW-1:0] hits;
        logic              page;
        logic              ready;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        b_we_o   = 1'b0;
        acc_op_o = ACC_HOLD;
        b_addr_o = {~r_q.page, r_q.idx};
        case (r_q.st)
            ST_CLEAR: begin                       // R4
                b_we_o   = 1'b1;
                acc_op_o = ACC_ZERO;
                r_d.idx  = r_q.idx + 1'b1;
                r_d.hits = '0;
                if (r_q.idx == IDX_LAST) r_d.st = ST_BOOK;
            end
            ST_BOOK: begin                        // R5
                b_addr_o = {~r_q.page, hit_bin};
                acc_op_o = ACC_INC;
                if (hit_valid) begin
                    b_we_o = 1'b1;
                    if (r_q.hits == HIT_LAST) begin
                        r_d.hits = '0;
                        r_d.st   = ST_INTEG;
                    end else begin
                        r_d.hits = r_q.hits + 1'b1;
                    end
                end
            end
            ST_INTEG: begin                       // R9
                b_we_o   = 1'b1;
                acc_op_o = ACC_SUM;
                r_d.idx  = r_q.idx + 1'b1;
                if (r_q.idx == IDX_LAST) r_d.st = ST_SWAP;
            end
            default: begin                        // ST_SWAP, R7
                acc_op_o  = ACC_ZERO;
                r_d.page  = ~r_q.page;
                r_d.ready = 1'b1;
                r_d.st    = ST_CLEAR;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '{st: ST_CLEAR, idx: '0, hits: '0, page: 1'b0, ready: 1'b0};
        else        r_q <= r_d;
    end

    assign page_o  = r_q.page;
    assign ready_o = r_q.ready;

    AST_SWAP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_SWAP) |=> (r_q.st == ST_CLEAR)); // R7
    AST_PAGE_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_SWAP) |=> (r_q.page != $past(r_q.page))); // R7
    AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != ST_SWAP) |=> $stable(r_q.page)); // R7
    AST_READY_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.ready |=> r_q.ready); // R8
    AST_HITS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.hits < HIT_CW'(HIT_TOTAL)); // R5
    AST_BOOK_FROM_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.st == ST_BOOK) |-> ($past(r_q.st) == ST_CLEAR)); // R4

endmodule

// File: rtl/tdc_bin_calibrator.sv
module tdc_bin_calibrator
    import tdc_cal_pkg::*;
#(
    parameter int BIN_W     = 7,
    parameter int DATA_W    = 16,
    parameter int HIT_TOTAL = 16384
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit_valid,
    input  logic [BIN_W-1:0]  hit_bin,
    output logic              cal_valid,
    output logic [DATA_W-1:0] cal_time,
    output logic              table_ready
);
    localparam int ADDR_W = BIN_W + 1;

    typedef struct packed {
        logic valid;
        logic gate;
    } conv_regs_t;

    conv_regs_t c_d, c_q;

    logic              page;
    logic              ready;
    logic [BIN_W:0]    b_addr;
    logic              b_we;
    acc_op_e           acc_op;
    logic [DATA_W-1:0] a_rdata, b_rdata, b_wdata;

    tdc_cal_seq #(.BIN_W(BIN_W), .HIT_TOTAL(HIT_TOTAL)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit_valid(hit_valid),
        .hit_bin  (hit_bin),
        .page_o   (page),
        .ready_o  (ready),
        .b_addr_o (b_addr),
        .b_we_o   (b_we),
        .acc_op_o (acc_op)
    );

    tdc_cal_accum #(.DATA_W(DATA_W)) u_accum (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (acc_op),
        .rd_word(b_rdata),
        .wr_word(b_wdata)
    );

    tdc_cal_dpram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk    (clk),
        .a_en   (hit_valid),
        .a_addr ({page, hit_bin}),
        .a_rdata(a_rdata),
        .b_addr (b_addr),
        .b_we   (b_we),
        .b_wdata(b_wdata),
        .b_rdata(b_rdata)
    );

    always_comb begin
        c_d       = c_q;
        c_d.valid = hit_valid;
        if (hit_valid) c_d.gate = ready;   // R2: no table yet, force zero
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign cal_valid   = c_q.valid;
    assign cal_time    = c_q.gate ? a_rdata : '0;
    assign table_ready = ready;

    AST_ZERO_BEFORE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_valid && !table_ready) |-> (cal_time == '0)); // R2
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid |=> cal_valid); // R3
    AST_TIME_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_valid |=> $stable(cal_time)); // R3
    AST_NO_LIVE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        b_we |-> (b_addr[BIN_W] != page)); // R10

endmodule

// File: tb/tdc_bin_calibrator_bench.sv
module tdc_bin_calibrator_bench;
    localparam int CLK_PERIOD = 10;
    localparam int BIN_W      = 7;
    localparam int DATA_W     = 16;
    localparam int HIT_TOTAL  = 200;
    localparam int NB         = 1 << BIN_W;
    localparam int WATCHDOG   = 20000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              hit_valid = 1'b0;
    logic [BIN_W-1:0]  hit_bin = '0;
    logic              cal_valid;
    logic [DATA_W-1:0] cal_time;
    logic              table_ready;

    tdc_bin_calibrator #(.BIN_W(BIN_W), .DATA_W(DATA_W), .HIT_TOTAL(HIT_TOTAL)) u_tdc_bin_calibrator (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit_valid  (hit_valid),
        .hit_bin    (hit_bin),
        .cal_valid  (cal_valid),
        .cal_time   (cal_time),
        .table_ready(table_ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    int swaps    = 0;
    bit done     = 0;
    bit compare_on = 0;

    // behavioural reference model
    int phase;        // 0 clear, 1 book, 2 integrate, 3 flip
    int step;
    int hits;
    int hist   [NB];
    int live   [NB];
    int fresh  [NB];
    bit m_ready;
    bit m_valid;
    int m_time;

    task automatic check(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            phase = 0; step = 0; hits = 0;
            m_ready = 0; m_valid = 0; m_time = 0;
        end else begin
            m_valid = hit_valid;
            if (hit_valid) m_time = m_ready ? live[hit_bin] : 0;
            case (phase)
                0: begin   // R4: hits here are not counted
                    if (step == NB - 1) begin
                        phase = 1; step = 0; hits = 0;
                        foreach (hist[i]) hist[i] = 0;
                    end else step++;
                end
                1: begin   // R5: count until the total is reached
                    if (hit_valid) begin
                        if (hist[hit_bin] < 65535) hist[hit_bin]++;
                        hits++;
                        if (hits == HIT_TOTAL) begin phase = 2; step = 0; end
                    end
                end
                2: begin   // R9: fixed-length integration
                    if (step == NB - 1) begin
                        int below;
                        below = 0;
                        for (int k = 0; k < NB; k++) begin
                            fresh[k] = 2 * below + hist[k];   // R6 centre of bin k
                            below += hist[k];
                        end
                        phase = 3;
                    end else step++;
                end
                default: begin  // R7 flip, R8 restart
                    foreach (live[i]) live[i] = fresh[i];
                    m_ready = 1; phase = 0; step = 0; swaps++;
                end
            endcase
        end
    end

    always @(negedge clk) begin
        if (compare_on && rst_n && !done) begin
            check("R3 cal_valid", cal_valid, m_valid);
            check(m_ready ? "R6 cal_time" : "R2 cal_time", cal_time, m_time);
            check("R7 table_ready", table_ready, m_ready);
        end
        if (cycles > WATCHDOG && !done) begin
            done = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, WATCHDOG);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    // mode 0 random dense, 1 bin 0 only, 2 top bin sparse, 3 ramp, 4 sparse gaps
    task automatic drive(input int mode, input int ncyc);
        int ramp = 0;
        for (int c = 0; c < ncyc; c++) begin
            @(negedge clk);
            case (mode)
                0: begin hit_valid = ($urandom % 10) < 7; hit_bin = BIN_W'($urandom); end
                1: begin hit_valid = 1'b1; hit_bin = '0; end
                2: begin hit_valid = $urandom % 2; hit_bin = '1; end
                3: begin hit_valid = 1'b1; hit_bin = BIN_W'(ramp); ramp++; end
                default: begin hit_valid = (c % 4) == 0; hit_bin = BIN_W'($urandom); end
            endcase
        end
    endtask

    initial begin
        hit_valid = 1'b1;
        hit_bin   = 7'd5;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 table_ready", table_ready, 0);
        check("R1 cal_valid", cal_valid, 0);
        check("R1 cal_time", cal_time, 0);
        rst_n = 1'b1;
        compare_on = 1;
        drive(0, 1200);   // R2 before first flip, then R6 random table
        drive(1, 1200);   // R4 R5: clear-phase and excess hits must not reach bin 0
        drive(2, 1200);   // top bin, sparse
        drive(3, 1200);   // ramp
        drive(4, 1600);   // R3 hold across gaps
        @(negedge clk);
        check("R8 rounds completed", swaps >= 6, 1);
        check("R8 ready still high", table_ready, 1);
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule